// File: doc/BRIEF.md
# Extension command dispatcher

This block carries out the eight overloadable extension command instructions of a processor core. Each command arrives with an opcode index from 0 to 7 and two operands. The low 12 bits of the first operand name a logical unit. The dispatcher turns that unit into a target device port and a 12-bit subdevice number. It then issues one request to that port, carrying a command code built from the subdevice number and the opcode index, together with both operands unchanged. The device's answer comes back as the destination value.

A 16-entry mapping table holds the logical units. Configuration logic loads it through a write port. Units 1 and 2 are wired to built-in fallbacks that answer 0 and all ones. A table entry can also point at the fallback by naming port index 4. Unit 0, an unmapped unit, or an entry that names a port index above 4 ends the command with an illegal-instruction trap and sends no device request. A device that reports an error ends the command with a configuration-error trap. Several logical units may point at one port, each with its own subdevice number.

The controller is a state machine with seven states. IDLE accepts a command and goes to DECODE. DECODE goes to ISSUE for an external port, to LOCAL for a fallback, and to FAULT when the unit is illegal. ISSUE holds the request until the port is ready, then goes to AWAIT. AWAIT goes to FINISH on a clean response and to FAULT on an error response. LOCAL goes to FINISH, or to FAULT when the fallback subdevice is unknown. FINISH and FAULT each last one cycle and return to IDLE.

Top module: `xcmd_dispatch`

## Requirements
- R1: After reset, cmd_ready is 1, and done, trap, trap_cause, result and every dev_req_valid bit are 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready stays 0 from the edge after acceptance until the command has ended with done.
- R3: The logical unit is cmd_rs1[11:0]. A table write (cfg_we) stores cfg_valid, cfg_lun, cfg_port and cfg_sub in entry cfg_idx. When several valid entries hold the same unit, the lowest index wins. Clearing cfg_valid removes the mapping.
- R4: A mapped unit with port index 0 to 3 raises only that port's dev_req_valid. dev_code is sub + k*4096, where bits [11:0] hold the subdevice and bits [14:12] hold the opcode index. dev_rs1 and dev_rs2 equal the accepted operands. The request stays unchanged until dev_req_ready is 1.
- R5: After a request has been taken, the first dev_rsp_valid from that port with dev_rsp_err 0 ends the command. done is 1, result carries that port's dev_rsp_data, and trap is 0.
- R6: Unit 0, a unit with no valid entry, or an entry with port index 5 to 7 ends the command with trap and trap_cause 1 (illegal instruction). No device request is made. done rises on the second clock edge after acceptance.
- R7: Unit 1 gives result 0 and unit 2 gives result all ones, whatever the table holds and whatever the opcode index is. done rises on the third clock edge after acceptance.
- R8: An entry with port index 4 uses the local fallback. Subdevice 0 gives 0 and subdevice 1 gives all ones. Any other subdevice gives trap_cause 2 (configuration error).
- R9: A device response with dev_rsp_err 1 ends the command with trap, trap_cause 2 and result 0.
- R10: Different units mapped to the same port reach it with their own subdevice numbers in dev_code.
- R11: done and trap are each high for exactly one cycle per command. trap_cause is 0 whenever trap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Dispatcher idle, command can be taken |
| cmd_op | input | 3 | Opcode index k |
| cmd_rs1 | input | 32 | First operand, low 12 bits hold the logical unit |
| cmd_rs2 | input | 32 | Second operand |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Table entry to write |
| cfg_valid | input | 1 | Entry in use |
| cfg_lun | input | 12 | Logical unit of the entry |
| cfg_port | input | 3 | Port index 0-3, 4 = local fallback |
| cfg_sub | input | 12 | Subdevice number |
| dev_req_valid | output | 4 | Per-port request strobe |
| dev_req_ready | input | 4 | Per-port request accept |
| dev_code | output | 15 | Command code, shared by all ports |
| dev_rs1 | output | 32 | First operand to device |
| dev_rs2 | output | 32 | Second operand to device |
| dev_rsp_valid | input | 4 | Per-port response strobe |
| dev_rsp_err | input | 4 | Per-port unsupported-code flag |
| dev_rsp_data | input | 128 | Per-port result, port p in bits [32p+31:32p] |
| done | output | 1 | Command finished, one cycle |
| result | output | 32 | Destination value, valid with done |
| trap | output | 1 | Command trapped, one cycle |
| trap_cause | output | 2 | 1 illegal instruction, 2 configuration error |

## Verification
The hardest case to reach from the ports is a table where two valid entries claim the same unit and a third names a port beyond the fallback. Only a lookup that picks the lowest index, and that bounds the port index, sends the command to the right place. The stimulus writes such conflicting and out-of-range entries on purpose. It points an entry at a built-in unit and another at unit 0. It then deletes an entry by rewriting it with cfg_valid low. The device stubs stall their ready signal for a different number of cycles on each port. This holds the request across several cycles while the dispatcher waits.

// File: rtl/xd_pkg.sv
package xd_pkg;

    localparam int XD_XLEN  = 32;
    localparam int XD_LUN_W = 12;
    localparam int XD_SUB_W = 12;
    localparam int XD_OP_W  = 3;
    localparam int XD_NPORT = 4;
    localparam int XD_NENT  = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECODE = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_AWAIT  = 3'd3,
        ST_LOCAL  = 3'd4,
        ST_FINISH = 3'd5,
        ST_FAULT  = 3'd6
    } xd_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ILLEGAL = 2'd1,
        CAUSE_CONFIG  = 2'd2
    } xd_cause_e;

endpackage

// File: rtl/xd_map_table.sv
module xd_map_table #(
    parameter int NENT   = 16,
    parameter int LUN_W  = 12,
    parameter int SUB_W  = 12,
    parameter int PORT_W = 3,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [LUN_W-1:0]  wr_lun,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [LUN_W-1:0]  look_lun,
    output logic              hit,
    output logic [PORT_W-1:0] hit_port,
    output logic [SUB_W-1:0]  hit_sub
);

    logic              ent_valid [NENT];
    logic [LUN_W-1:0]  ent_lun   [NENT];
    logic [PORT_W-1:0] ent_port  [NENT];
    logic [SUB_W-1:0]  ent_sub   [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ent_valid[i] <= 1'b0;
                ent_lun[i]   <= '0;
                ent_port[i]  <= '0;
                ent_sub[i]   <= '0;
            end
        end else if (wr_en) begin
            ent_valid[wr_idx] <= wr_valid;
            ent_lun[wr_idx]   <= wr_lun;
            ent_port[wr_idx]  <= wr_port;
            ent_sub[wr_idx]   <= wr_sub;
        end
    end

    // Scan from the top so that the lowest matching index is left standing.
    always_comb begin
        hit      = 1'b0;
        hit_port = '0;
        hit_sub  = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_lun[i] == look_lun) begin
                hit      = 1'b1;
                hit_port = ent_port[i];
                hit_sub  = ent_sub[i];
            end
        end
    end

endmodule

// File: rtl/xd_port_mux.sv
module xd_port_mux #(
    parameter int NPORT  = 4,
    parameter int XLEN   = 32,
    parameter int PORT_W = 3
) (
    input  logic [PORT_W-1:0]     sel,
    input  logic                  req_in,
    output logic                  req_taken,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [XLEN-1:0]       rsp_data,
    output logic [NPORT-1:0]      dev_req_valid,
    input  logic [NPORT-1:0]      dev_req_ready,
    input  logic [NPORT-1:0]      dev_rsp_valid,
    input  logic [NPORT-1:0]      dev_rsp_err,
    input  logic [NPORT*XLEN-1:0] dev_rsp_data
);

    for (genvar g = 0; g < NPORT; g++) begin : g_req
        assign dev_req_valid[g] = req_in && (sel == PORT_W'(g));
    end

    always_comb begin
        req_taken = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (sel == PORT_W'(i)) begin
                req_taken = req_in && dev_req_ready[i];
                rsp_valid = dev_rsp_valid[i];
                rsp_err   = dev_rsp_err[i];
                rsp_data  = dev_rsp_data[i*XLEN +: XLEN];
            end
        end
    end

endmodule

// File: rtl/xd_fallback.sv
module xd_fallback #(
    parameter int XLEN  = 32,
    parameter int SUB_W = 12
) (
    input  logic [SUB_W-1:0] sub,
    output logic             err,
    output logic [XLEN-1:0]  data
);

    // Subdevice 0 answers zero, subdevice 1 answers all ones.
    always_comb begin
        err  = 1'b0;
        data = '0;
        if (sub == SUB_W'(1)) begin
            data = '1;
        end else if (sub != '0) begin
            err = 1'b1;
        end
    end

endmodule

// File: rtl/xcmd_dispatch.sv
module xcmd_dispatch
    import xd_pkg::*;
#(
    parameter int XLEN   = XD_XLEN,
    parameter int LUN_W  = XD_LUN_W,
    parameter int SUB_W  = XD_SUB_W,
    parameter int OP_W   = XD_OP_W,
    parameter int NPORT  = XD_NPORT,
    parameter int NENT   = XD_NENT,
    localparam int PORT_W = $clog2(NPORT + 1),
    localparam int IDX_W  = $clog2(NENT),
    localparam int CODE_W = SUB_W + OP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [OP_W-1:0]       cmd_op,
    input  logic [XLEN-1:0]       cmd_rs1,
    input  logic [XLEN-1:0]       cmd_rs2,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_valid,
    input  logic [LUN_W-1:0]      cfg_lun,
    input  logic [PORT_W-1:0]     cfg_port,
    input  logic [SUB_W-1:0]      cfg_sub,
    output logic [NPORT-1:0]      dev_req_valid,
    input  logic [NPORT-1:0]      dev_req_ready,
    output logic [CODE_W-1:0]     dev_code,
    output logic [XLEN-1:0]       dev_rs1,
    output logic [XLEN-1:0]       dev_rs2,
    input  logic [NPORT-1:0]      dev_rsp_valid,
    input  logic [NPORT-1:0]      dev_rsp_err,
    input  logic [NPORT*XLEN-1:0] dev_rsp_data,
    output logic                  done,
    output logic [XLEN-1:0]       result,
    output logic                  trap,
    output logic [1:0]            trap_cause
);

    localparam logic [PORT_W-1:0] FB_PORT = PORT_W'(NPORT);
    localparam logic [LUN_W-1:0]  LUN_ZERO_FB = LUN_W'(1);
    localparam logic [LUN_W-1:0]  LUN_ONES_FB = LUN_W'(2);

    xd_state_e         state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [XLEN-1:0]   rs1_q, rs2_q;
    logic [PORT_W-1:0] port_q;
    logic [SUB_W-1:0]  sub_q;
    logic [XLEN-1:0]   res_q;
    xd_cause_e         cause_q;

    logic [LUN_W-1:0]  lun;
    logic              tbl_hit;
    logic [PORT_W-1:0] tbl_port;
    logic [SUB_W-1:0]  tbl_sub;
    logic              mux_taken, mux_rsp_valid, mux_rsp_err;
    logic [XLEN-1:0]   mux_rsp_data;
    logic              fb_err;
    logic [XLEN-1:0]   fb_data;
    logic              lun_builtin, to_port, to_local;

    assign lun = rs1_q[LUN_W-1:0];

    xd_map_table #(
        .NENT(NENT), .LUN_W(LUN_W), .SUB_W(SUB_W), .PORT_W(PORT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_lun   (cfg_lun),
        .wr_port  (cfg_port),
        .wr_sub   (cfg_sub),
        .look_lun (lun),
        .hit      (tbl_hit),
        .hit_port (tbl_port),
        .hit_sub  (tbl_sub)
    );

    xd_port_mux #(
        .NPORT(NPORT), .XLEN(XLEN), .PORT_W(PORT_W)
    ) u_mux (
        .sel           (port_q),
        .req_in        (state_q == ST_ISSUE),
        .req_taken     (mux_taken),
        .rsp_valid     (mux_rsp_valid),
        .rsp_err       (mux_rsp_err),
        .rsp_data      (mux_rsp_data),
        .dev_req_valid (dev_req_valid),
        .dev_req_ready (dev_req_ready),
        .dev_rsp_valid (dev_rsp_valid),
        .dev_rsp_err   (dev_rsp_err),
        .dev_rsp_data  (dev_rsp_data)
    );

    xd_fallback #(
        .XLEN(XLEN), .SUB_W(SUB_W)
    ) u_fallback (
        .sub  (sub_q),
        .err  (fb_err),
        .data (fb_data)
    );

    assign lun_builtin = (lun == LUN_ZERO_FB) || (lun == LUN_ONES_FB);
    assign to_port     = tbl_hit && (tbl_port < FB_PORT);
    assign to_local    = tbl_hit && (tbl_port == FB_PORT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                if (lun == '0)        state_d = ST_FAULT;
                else if (lun_builtin) state_d = ST_LOCAL;
                else if (to_port)     state_d = ST_ISSUE;
                else if (to_local)    state_d = ST_LOCAL;
                else                  state_d = ST_FAULT;
            end
            ST_ISSUE:  if (mux_taken) state_d = ST_AWAIT;
            ST_AWAIT:  if (mux_rsp_valid) state_d = mux_rsp_err ? ST_FAULT : ST_FINISH;
            ST_LOCAL:  state_d = fb_err ? ST_FAULT : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Command context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            rs1_q   <= '0;
            rs2_q   <= '0;
            port_q  <= '0;
            sub_q   <= '0;
            res_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= cmd_op;
                        rs1_q   <= cmd_rs1;
                        rs2_q   <= cmd_rs2;
                        res_q   <= '0;
                        cause_q <= CAUSE_NONE;
                    end
                end
                ST_DECODE: begin
                    cause_q <= CAUSE_ILLEGAL;
                    if (lun == LUN_ZERO_FB) begin
                        port_q <= FB_PORT;
                        sub_q  <= SUB_W'(0);
                    end else if (lun == LUN_ONES_FB) begin
                        port_q <= FB_PORT;
                        sub_q  <= SUB_W'(1);
                    end else begin
                        port_q <= tbl_port;
                        sub_q  <= tbl_sub;
                    end
                end
                ST_LOCAL: begin
                    cause_q <= CAUSE_CONFIG;
                    res_q   <= fb_err ? '0 : fb_data;
                end
                ST_AWAIT: begin
                    if (mux_rsp_valid) begin
                        cause_q <= CAUSE_CONFIG;
                        res_q   <= mux_rsp_err ? '0 : mux_rsp_data;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_FINISH) || (state_q == ST_FAULT);
        trap       = (state_q == ST_FAULT);
        trap_cause = (state_q == ST_FAULT) ? cause_q : CAUSE_NONE;
        result     = (state_q == ST_FINISH) ? res_q : '0;
        dev_code   = {op_q, sub_q};
        dev_rs1    = rs1_q;
        dev_rs2    = rs2_q;
    end

    // R2: once taken, the next command waits
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R4: a waiting request does not move
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_req_valid) && !(|(dev_req_valid & dev_req_ready)))
        |=> (dev_req_valid == $past(dev_req_valid)) && $stable(dev_code)
            && $stable(dev_rs1) && $stable(dev_rs2));

    // R6: an illegal trap is never preceded by a device request
    p_illegal_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && trap_cause == CAUSE_ILLEGAL) |-> ($past(dev_req_valid) == '0));

    // R11: done is a single-cycle strobe
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: trap is a single-cycle strobe
    p_trap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    // R9: an error response is followed by a configuration trap
    p_err_traps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_AWAIT) && |(dev_rsp_valid & dev_rsp_err & dev_req_valid_last))
        |=> (trap && trap_cause == CAUSE_CONFIG));

    logic [NPORT-1:0] dev_req_valid_last;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             dev_req_valid_last <= '0;
        else if (|dev_req_valid) dev_req_valid_last <= dev_req_valid;
    end

endmodule

// File: tb/xcmd_dispatch_test.sv
module xcmd_dispatch_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_rs1 = '0, cmd_rs2 = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [11:0] cfg_lun = '0;
    logic [2:0]  cfg_port = '0;
    logic [11:0] cfg_sub = '0;
    logic [NP-1:0]    dev_req_valid;
    logic [NP-1:0]    dev_req_ready = '0;
    logic [14:0]      dev_code;
    logic [31:0]      dev_rs1, dev_rs2;
    logic [NP-1:0]    dev_rsp_valid = '0;
    logic [NP-1:0]    dev_rsp_err = '0;
    logic [NP*32-1:0] dev_rsp_data = '0;
    logic        done;
    logic [31:0] result;
    logic        trap;
    logic [1:0]  trap_cause;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcmd_dispatch uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_lun(cfg_lun), .cfg_port(cfg_port), .cfg_sub(cfg_sub),
        .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
        .dev_code(dev_code), .dev_rs1(dev_rs1), .dev_rs2(dev_rs2),
        .dev_rsp_valid(dev_rsp_valid), .dev_rsp_err(dev_rsp_err),
        .dev_rsp_data(dev_rsp_data),
        .done(done), .result(result), .trap(trap), .trap_cause(trap_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bench-side table model
    bit          m_valid [16];
    int          m_lun   [16];
    int          m_port  [16];
    int          m_sub   [16];

    // Device stub state
    int          stall_set [NP];
    int          stall     [NP];
    bit          acc       [NP];
    int          cd        [NP];
    logic [31:0] pend_data [NP];
    bit          pend_err  [NP];
    int          seen_port;
    logic [14:0] seen_code;
    logic [31:0] seen_rs1, seen_rs2;
    int          seen_count;

    function automatic logic [31:0] dev_fn(int p, logic [14:0] code,
                                           logic [31:0] a, logic [31:0] b);
        return b + (a ^ (32'h1111 * (p + 1))) + 32'(code);
    endfunction

    // Device stubs: ready after a per-port stall, answer two cycles after the handshake
    initial begin
        for (int p = 0; p < NP; p++) begin
            stall[p] = 0; acc[p] = 0; cd[p] = 0; pend_data[p] = '0; pend_err[p] = 0;
        end
        forever begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                dev_rsp_valid[p] = 1'b0;
                dev_rsp_err[p]   = 1'b0;
                if (cd[p] > 0) begin
                    cd[p]--;
                    if (cd[p] == 0) begin
                        dev_rsp_valid[p] = 1'b1;
                        dev_rsp_err[p]   = pend_err[p];
                        dev_rsp_data[p*32 +: 32] = pend_data[p];
                    end
                end
                if (acc[p]) begin
                    acc[p] = 0;
                    dev_req_ready[p] = 1'b0;
                    cd[p] = 2;
                end else if (dev_req_valid[p]) begin
                    if (!dev_req_ready[p] && stall[p] > 0) stall[p]--;
                    if (!dev_req_ready[p] && stall[p] == 0) dev_req_ready[p] = 1'b1;
                    if (dev_req_ready[p]) begin
                        acc[p] = 1;
                        seen_port = p;
                        seen_code = dev_code;
                        seen_rs1 = dev_rs1;
                        seen_rs2 = dev_rs2;
                        seen_count++;
                        pend_err[p]  = (dev_code[11:0] >= 12'd8);
                        pend_data[p] = dev_fn(p, dev_code, dev_rs1, dev_rs2);
                    end
                end
            end
        end
    end

    // Every-clock monitor
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            check($countones(dev_req_valid) <= 1, "R4", "request on more than one port",
                  64'(dev_req_valid), 64'd0);
            check(trap ? done : 1'b1, "R11", "trap without done", 64'(trap), 64'(done));
            check(!trap ? (trap_cause == 2'd0) : 1'b1, "R11", "cause without trap",
                  64'(trap_cause), 64'd0);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic cfg_write(input int idx, input bit v, input int lun, input int port, input int sub);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v;
        cfg_lun = 12'(lun); cfg_port = 3'(port); cfg_sub = 12'(sub);
        m_valid[idx] = v; m_lun[idx] = lun; m_port[idx] = port; m_sub[idx] = sub;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // kind: 0 result, 1 illegal trap, 2 configuration trap
    task automatic run_cmd(input int op, input logic [31:0] rs1, input logic [31:0] rs2,
                           input string req);
        int lun, port, sub, kind, lat, exp_lat, idx;
        logic [31:0] exp_res;
        logic [14:0] exp_code;
        lun = int'(rs1[11:0]);
        port = -1; sub = 0; kind = 0; exp_res = '0; exp_lat = -1;
        if (lun == 0) begin
            kind = 1;
        end else if (lun == 1 || lun == 2) begin
            port = 4; sub = lun - 1;
        end else begin
            idx = -1;
            for (int i = 15; i >= 0; i--) if (m_valid[i] && m_lun[i] == lun) idx = i;
            if (idx < 0 || m_port[idx] > 4) kind = 1;
            else begin port = m_port[idx]; sub = m_sub[idx]; end
        end
        exp_code = 15'(sub + op * 4096);
        if (kind == 1) exp_lat = 2;
        else if (port == 4) begin
            exp_lat = 3;
            if (sub == 0) exp_res = '0;
            else if (sub == 1) exp_res = '1;
            else kind = 2;
        end else begin
            if (sub >= 8) kind = 2;
            else exp_res = dev_fn(port, exp_code, rs1, rs2);
            stall[port] = stall_set[port];
        end
        seen_port = -1; seen_count = 0;

        @(negedge clk);
        check(cmd_ready, req, "cmd_ready before issue", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_rs1 = rs1; cmd_rs2 = rs2;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_rs1 = 32'hDEAD_0000; cmd_rs2 = 32'hBEEF_0000; cmd_op = 3'd0;
        lat = 1;
        check(!cmd_ready, "R2", "cmd_ready after accept", 64'(cmd_ready), 64'd0);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (!done) check(!cmd_ready, "R2", "cmd_ready while busy", 64'(cmd_ready), 64'd0);
        end
        check(done, req, "done seen", 64'(done), 64'd1);
        if (exp_lat > 0) check(lat == exp_lat, req, "done latency", 64'(lat), 64'(exp_lat));
        check(trap == (kind != 0), req, "trap", 64'(trap), 64'(kind != 0));
        check(trap_cause == 2'(kind), req, "trap_cause", 64'(trap_cause), 64'(kind));
        check(result == exp_res, req, "result", 64'(result), 64'(exp_res));
        if (port >= 0 && port < 4) begin
            check(seen_count == 1 && seen_port == port, req, "target port",
                  64'(seen_port), 64'(port));
            check(seen_code == exp_code, req, "dev_code", 64'(seen_code), 64'(exp_code));
            check(seen_rs1 == rs1 && seen_rs2 == rs2, req, "operands",
                  64'(seen_rs1), 64'(rs1));
        end else begin
            check(seen_count == 0, req, "no device request", 64'(seen_count), 64'd0);
        end
        @(negedge clk);
        check(!done && !trap && cmd_ready, "R11", "strobes one cycle",
              64'({done, trap, cmd_ready}), 64'b001);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_lun[i] = 0; m_port[i] = 0; m_sub[i] = 0; end
        for (int p = 0; p < NP; p++) stall_set[p] = p;
        seen_count = 0; seen_port = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cmd_ready == 1'b1, "R1", "cmd_ready", 64'(cmd_ready), 64'd1);
        check(!done && !trap && trap_cause == 2'd0, "R1", "done/trap/cause",
              64'({done, trap, trap_cause}), 64'd0);
        check(result == '0 && dev_req_valid == '0, "R1", "result/requests",
              64'({result, dev_req_valid}), 64'd0);

        // R6: empty table, unit 0 and an unmapped unit
        run_cmd(0, 32'h0000_5000, 32'h1, "R6");
        run_cmd(3, 32'h0000_0021, 32'h2, "R6");

        cfg_write(0, 1, 32, 0, 0);
        cfg_write(1, 1, 33, 0, 1);
        cfg_write(2, 1, 34, 1, 0);
        cfg_write(3, 1, 35, 3, 5);
        cfg_write(4, 1, 40, 4, 1);
        cfg_write(5, 1, 41, 4, 0);
        cfg_write(6, 1, 42, 4, 7);
        cfg_write(7, 1, 50, 2, 9);
        cfg_write(8, 1, 60, 6, 0);
        cfg_write(9, 1, 33, 2, 2);
        cfg_write(10, 1, 0, 0, 0);
        cfg_write(11, 1, 1, 3, 3);
        cfg_write(12, 1, 70, 1, 3);

        // R4, R5: device ports with opcode and operands
        run_cmd(0, 32'hABCD_E020, 32'h1234_5678, "R4");
        run_cmd(7, 32'h0000_0022, 32'hFFFF_0000, "R5");
        run_cmd(5, 32'h5555_5023, 32'h0F0F_0F0F, "R5");
        // R10: two units on port 0 with different subdevices
        run_cmd(2, 32'h0000_1020, 32'h0000_0001, "R10");
        // R3: duplicate unit 33, lowest index (port 0, sub 1) wins
        run_cmd(4, 32'h0001_0021, 32'h0000_0002, "R3");
        run_cmd(1, 32'h0000_0046, 32'h0000_0003, "R3");
        // R7: built-in units win over the table entry for unit 1
        run_cmd(6, 32'h7777_7001, 32'h9, "R7");
        run_cmd(3, 32'h0000_0002, 32'h9, "R7");
        // R8: table fallback entries
        run_cmd(0, 32'h0000_0028, 32'h0, "R8");
        run_cmd(2, 32'h0000_0029, 32'h0, "R8");
        run_cmd(1, 32'h0000_002A, 32'h0, "R8");
        // R9: device error response
        run_cmd(0, 32'h0000_0032, 32'h5, "R9");
        // R6: port index beyond the fallback, and unit 0 in the table
        run_cmd(0, 32'h0000_003C, 32'h5, "R6");
        run_cmd(2, 32'h0000_0000, 32'h5, "R6");
        // R3: removing a mapping
        cfg_write(12, 0, 70, 1, 3);
        run_cmd(0, 32'h0000_0046, 32'h3, "R3");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule